// File: doc/BRIEF.md
# Selectable Clock Prescaler with External Count Source

This block supplies the count-enable for a timer/counter. A 3-bit select code picks where that enable comes from. It can be off, a division of the system clock, or a chosen edge of an external count pin. The result is a one-clock `tick` pulse. The timer it feeds advances by one on every clock where `tick` is high.

All divided rates come from one shared free-running prescaler counter. A rate of 2^k ticks whenever the low k bits of that counter are zero. Changing the select code therefore never restarts the count; the new rate joins the same grid of counter values. The external pin is brought into the clock domain through two flip-flops, and its edge is detected after that.

The `WIDE_TABLE` parameter chooses between two select tables. The narrow table offers five ratios and the two external-pin settings. The wide table offers seven ratios and has no external setting.

Top module: `tick_prescaler`

## Requirements
- R1: While `rst` is high, `tick` is 0. Reset clears the prescaler counter to zero. Count the clock edges from the first edge at which `rst` is sampled low, with that edge as number 1. After edge m, a divide-by-N setting drives `tick` to 1 exactly when (m-1) mod N == 0. So every divide setting ticks right after the first edge out of reset.
- R2: Code 3'b000 turns the tick source off in both tables. `tick` stays 0 whatever `ext_pin` does.
- R3: With `WIDE_TABLE`=0, codes 3'b001, 3'b010, 3'b011, 3'b100 and 3'b101 divide the clock by 1, 8, 64, 256 and 1024.
- R4: With `WIDE_TABLE`=0, code 3'b111 ticks on a rising edge of `ext_pin`, and code 3'b110 ticks on a falling edge. Let `ext_pin` be sampled at edge k as 1, and at edge k-1 as 0 (the reverse for a falling edge). Then `tick` is high for the one cycle after edge k+2.
- R5: With `WIDE_TABLE`=1, codes 3'b001 to 3'b111 divide by 1, 8, 32, 64, 128, 256 and 1024, in that order.
- R6: With `WIDE_TABLE`=1, `ext_pin` has no effect on `tick` under any code.
- R7: The select code may be held at any setting other than divide-by-1. While it is held, `tick` is never high on two clocks in a row.
- R8: While the code selects divide-by-1, `tick` is high on every clock after the first one outside reset.
- R9: The prescaler counter steps by one on every clock outside reset, under every code. A code change takes effect at the next clock edge. The new rate stays aligned to the R1 edge count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_sel | input | 3 | Tick source select code |
| ext_pin | input | 1 | Asynchronous external count pin |
| tick | output | 1 | Registered one-cycle count enable |

## Verification
The output is registered. A divided tick therefore shows up one edge after the counter value that caused it. A code change applied between edges is in force from the next edge. An external edge reaches `tick` at the third edge after the pin is first sampled in its new state.

The bench counts edges since reset and keeps a short shift history of the sampled pin. From these it predicts `tick` for every single cycle, each table and each code. It compares half a cycle after each edge, so register timing never blurs the comparison. A long phase with random code changes on both variants checks the shared counter's alignment.

// File: rtl/tick_prescaler_pkg.sv
package tick_prescaler_pkg;

  localparam int unsigned SEL_W   = 3;
  localparam int unsigned SHIFT_W = 4;

  typedef enum logic [1:0] {
    SRC_OFF  = 2'd0,
    SRC_DIV  = 2'd1,
    SRC_FALL = 2'd2,
    SRC_RISE = 2'd3
  } tick_src_e;

  typedef struct packed {
    tick_src_e          src;
    logic [SHIFT_W-1:0] shift;
  } sel_plan_t;

  // Translate a select code into a source and a log2 division ratio.
  function automatic sel_plan_t decode_sel(input logic wide_tbl,
                                           input logic [SEL_W-1:0] code);
    sel_plan_t p;
    p.src   = SRC_DIV;
    p.shift = '0;
    if (code == 3'd0) begin
      p.src = SRC_OFF;
    end else if (wide_tbl) begin
      case (code)
        3'd1:    p.shift = 4'd0;
        3'd2:    p.shift = 4'd3;
        3'd3:    p.shift = 4'd5;
        3'd4:    p.shift = 4'd6;
        3'd5:    p.shift = 4'd7;
        3'd6:    p.shift = 4'd8;
        default: p.shift = 4'd10;
      endcase
    end else begin
      case (code)
        3'd1:    p.shift = 4'd0;
        3'd2:    p.shift = 4'd3;
        3'd3:    p.shift = 4'd6;
        3'd4:    p.shift = 4'd8;
        3'd5:    p.shift = 4'd10;
        3'd6:    p.src   = SRC_FALL;
        default: p.src   = SRC_RISE;
      endcase
    end
    return p;
  endfunction

endpackage

// File: rtl/prescale_count.sv
module prescale_count #(
  parameter int unsigned W = 10
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] cnt
);

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt + 1'b1;
  end

  AST_FREE_RUN: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> cnt == W'($past(cnt) + 1'b1)); // R9

endmodule

// File: rtl/tap_match.sv
module tap_match #(
  parameter int unsigned W  = 10,
  parameter int unsigned SW = 4
) (
  input  logic [W-1:0]  cnt,
  input  logic [SW-1:0] shift,
  output logic          hit
);

  logic [W-1:0] bit_ok;

  // A bit below the shift position must be zero; bits above are don't-care.
  for (genvar gi = 0; gi < W; gi++) begin : g_bit
    assign bit_ok[gi] = (32'(gi) >= 32'(shift)) || !cnt[gi];
  end

  assign hit = &bit_ok;

endmodule

// File: rtl/pin_edge_sync.sv
module pin_edge_sync (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic rise,
  output logic fall
);

  logic s1, s2, s3;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= pin;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign rise = s2 & ~s3;
  assign fall = ~s2 & s3;

  AST_RISE_ORIGIN: assert property (@(posedge clk) disable iff (rst)
    (rise && !$past(rst,1) && !$past(rst,2) && !$past(rst,3))
      |-> ($past(pin,2) && !$past(pin,3))); // R4
  AST_FALL_ORIGIN: assert property (@(posedge clk) disable iff (rst)
    (fall && !$past(rst,1) && !$past(rst,2) && !$past(rst,3))
      |-> (!$past(pin,2) && $past(pin,3))); // R4

endmodule

// File: rtl/tick_prescaler.sv
module tick_prescaler
  import tick_prescaler_pkg::*;
#(
  parameter bit          WIDE_TABLE = 1'b0,
  parameter int unsigned PS_W       = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] clk_sel,
  input  logic             ext_pin,
  output logic             tick
);

  logic [PS_W-1:0] ps_cnt;
  logic            tap_hit;
  logic            pin_rise;
  logic            pin_fall;
  logic            tick_d;
  sel_plan_t       plan;

  assign plan = decode_sel(WIDE_TABLE, clk_sel);

  prescale_count #(.W(PS_W)) u_count (
    .clk (clk),
    .rst (rst),
    .cnt (ps_cnt)
  );

  tap_match #(.W(PS_W), .SW(SHIFT_W)) u_tap (
    .cnt   (ps_cnt),
    .shift (plan.shift),
    .hit   (tap_hit)
  );

  pin_edge_sync u_sync (
    .clk  (clk),
    .rst  (rst),
    .pin  (ext_pin),
    .rise (pin_rise),
    .fall (pin_fall)
  );

  always_comb begin
    case (plan.src)
      SRC_DIV:  tick_d = tap_hit;
      SRC_FALL: tick_d = pin_fall;
      SRC_RISE: tick_d = pin_rise;
      default:  tick_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) tick <= 1'b0;
    else     tick <= tick_d;
  end

  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
    ($past(clk_sel) == 3'd0) |-> !tick); // R2
  AST_DIV1_EVERY: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(clk_sel) == 3'd1) |-> tick); // R8
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    (tick && clk_sel != 3'd1 && clk_sel == $past(clk_sel)) |=> !tick); // R7

endmodule

// File: tb/sim_tick_prescaler.sv
module sim_tick_prescaler;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pin = 1'b0;
  logic [2:0] sel_s = 3'd2;
  logic [2:0] sel_x = 3'd3;
  logic       tick_s, tick_x;

  int         checks = 0;
  int         failures = 0;
  int         cyc;
  logic [3:0] ph;
  logic [15:0] lfsr = 16'hACE1;
  bit         done = 0;

  always #5 clk = ~clk;

  tick_prescaler #(.WIDE_TABLE(1'b0), .PS_W(10)) u0 (
    .clk(clk), .rst(rst), .clk_sel(sel_s), .ext_pin(pin), .tick(tick_s));

  tick_prescaler #(.WIDE_TABLE(1'b1), .PS_W(10)) u1 (
    .clk(clk), .rst(rst), .clk_sel(sel_x), .ext_pin(pin), .tick(tick_x));

  // Edge count since reset and sampled-pin history, both per the requirements.
  always @(posedge clk) begin
    if (rst) begin
      cyc <= 0;
      ph  <= 4'b0;
    end else begin
      cyc <= cyc + 1;
      ph  <= {ph[2:0], pin};
    end
  end

  // Pin wiggles all run long, changing away from the active edge.
  always @(negedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    pin  <= lfsr[0] ^ lfsr[7];
  end

  function automatic logic exp_tick(input bit wide, input logic [2:0] s,
                                    input int c, input logic [3:0] h);
    int n;
    n = 0;
    if (!wide) begin
      case (s)
        3'd1: n = 1;
        3'd2: n = 8;
        3'd3: n = 64;
        3'd4: n = 256;
        3'd5: n = 1024;
        3'd6: return ~h[2] & h[3];
        3'd7: return h[2] & ~h[3];
        default: n = 0;
      endcase
    end else begin
      case (s)
        3'd1: n = 1;
        3'd2: n = 8;
        3'd3: n = 32;
        3'd4: n = 64;
        3'd5: n = 128;
        3'd6: n = 256;
        3'd7: n = 1024;
        default: n = 0;
      endcase
    end
    if (n == 0) return 1'b0;
    return ((c - 1) % n) == 0;
  endfunction

  task automatic judge(input string tag, input int bad, input logic act,
                       input logic exp, input int at);
    checks++;
    if (bad > 0) begin
      failures++;
      $display("FAIL %s: %0d bad cycles, first at edge %0d actual=%0b expected=%0b",
               tag, bad, at, act, exp);
    end
  endtask

  task automatic run_window(input logic [2:0] ss, input logic [2:0] sx, input int n,
                            input string tag_s, input string tag_x);
    int bs, bx, at_s, at_x;
    logic as_, es, ax, ex;
    bs = 0; bx = 0; at_s = 0; at_x = 0;
    as_ = 0; es = 0; ax = 0; ex = 0;
    sel_s = ss;
    sel_x = sx;
    repeat (n) begin
      @(negedge clk);
      if (tick_s !== exp_tick(1'b0, sel_s, cyc, ph)) begin
        if (bs == 0) begin at_s = cyc; as_ = tick_s; es = exp_tick(1'b0, sel_s, cyc, ph); end
        bs++;
      end
      if (tick_x !== exp_tick(1'b1, sel_x, cyc, ph)) begin
        if (bx == 0) begin at_x = cyc; ax = tick_x; ex = exp_tick(1'b1, sel_x, cyc, ph); end
        bx++;
      end
    end
    judge(tag_s, bs, as_, es, at_s);
    judge(tag_x, bx, ax, ex, at_x);
  endtask

  task automatic run_shuffle(input int n);
    int bs, bx, at_s, at_x;
    logic as_, es, ax, ex;
    bs = 0; bx = 0; at_s = 0; at_x = 0;
    as_ = 0; es = 0; ax = 0; ex = 0;
    repeat (n) begin
      @(negedge clk);
      if (tick_s !== exp_tick(1'b0, sel_s, cyc, ph)) begin
        if (bs == 0) begin at_s = cyc; as_ = tick_s; es = exp_tick(1'b0, sel_s, cyc, ph); end
        bs++;
      end
      if (tick_x !== exp_tick(1'b1, sel_x, cyc, ph)) begin
        if (bx == 0) begin at_x = cyc; ax = tick_x; ex = exp_tick(1'b1, sel_x, cyc, ph); end
        bx++;
      end
      if ($urandom_range(0, 15) == 0) sel_s = 3'($urandom_range(0, 7));
      if ($urandom_range(0, 15) == 0) sel_x = 3'($urandom_range(0, 7));
    end
    judge("R9 R7 narrow table, random code changes", bs, as_, es, at_s);
    judge("R9 R7 wide table, random code changes", bx, ax, ex, at_x);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    int bad;
    bad = 0;
    repeat (6) begin
      @(negedge clk);
      if (tick_s !== 1'b0 || tick_x !== 1'b0) bad++;
    end
    judge("R1 tick low during reset", bad, tick_s | tick_x, 1'b0, 0);
    rst = 1'b0;
    run_window(3'd2, 3'd3, 300, "R1 R9 narrow /8 phase from reset",
               "R1 R9 wide /32 phase from reset");
    run_window(3'd0, 3'd0, 2100, "R2 narrow off, pin ignored", "R2 wide off, pin ignored");
    run_window(3'd1, 3'd1, 2100, "R8 R3 narrow /1", "R8 R5 wide /1");
    run_window(3'd2, 3'd2, 2100, "R3 R7 narrow /8", "R5 R7 wide /8");
    run_window(3'd3, 3'd3, 2100, "R3 narrow /64", "R5 wide /32");
    run_window(3'd4, 3'd4, 2100, "R3 narrow /256", "R5 wide /64");
    run_window(3'd5, 3'd5, 2100, "R3 narrow /1024", "R5 wide /128");
    run_window(3'd6, 3'd6, 2100, "R4 R7 narrow falling pin edge",
               "R5 R6 wide /256 pin ignored");
    run_window(3'd7, 3'd7, 2100, "R4 R7 narrow rising pin edge",
               "R5 R6 wide /1024 pin ignored");
    run_shuffle(4000);
    finish_run();
  end

  initial begin
    #(200000 * 10);
    failures++;
    $display("FAIL watchdog: run did not complete actual=hung expected=done");
    finish_run();
  end

endmodule